// File: doc/BRIEF.md
# Butterfly Bit Permutation Unit

This block rearranges the bits of a 64-bit data word through a staged butterfly network. A 2-bit operation select picks one of four permutation families:

- **Generalised reverse** swaps neighbouring bit groups at every enabled stage.
- **Generalised OR-combine** ORs the swapped copy into the running value.
- **Zip shuffle** interleaves the inner halves of bit groups.
- **Unshuffle** undoes the shuffle.

The low bits of a control word enable the individual stages. A word-mode input limits the work to the low 32 bits.

The network itself is purely combinational. Its result is captured in one output register, so the value for the inputs presented at a rising clock edge appears on the output after that edge. A new operation can be started every cycle. The control value is supplied directly on its own port; nothing is decoded from an instruction. Typical uses include bit reversal, byte swap, bit-matrix transposition and smearing set bits across their groups.

Top module: `bperm_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` is zero. After reset, `result_o` holds the result for the inputs sampled at the previous rising clock edge.
- R2: With `op_i` = 2'b00 (reverse), stage k (shift 2^k, k = 0..5) is enabled by `ctrl_i[k]`. Stages run in increasing shift order. Each enabled stage swaps adjacent groups of 2^k bits. The result is equivalent to bit i taking input bit (i XOR ctrl), so control 63 gives a full bit reversal and control 56 gives a byte swap.
- R3: With `op_i` = 2'b01 (OR-combine), the stages, masks and order are those of R2, but each enabled stage ORs the swapped copy into the value. Result bit i is the OR of all input bits j for which i XOR j has ones only where the control has ones.
- R4: With `op_i` = 2'b10 (shuffle), only `ctrl_i[4:0]` is used and `ctrl_i[5]` has no effect. Stage k exchanges the two inner quarter-groups within each group of 2^(k+2) bits. The stages run in the order shift 16, 8, 4, 2, 1. Applying shuffle with control 31 three times transposes the word viewed as an 8x8 bit matrix, where bit 8*row+col becomes bit 8*col+row.
- R5: With `op_i` = 2'b11 (unshuffle), the stages of R4 run in the order shift 1, 2, 4, 8, 16. For every control value c in 0..31, unshuffle(shuffle(x, c), c) = x.
- R6: With `word_i` = 1, only `data_i[31:0]` takes part and `result_o[63:32]` is zero. `ctrl_i[5]` is ignored for reverse and OR-combine, and `ctrl_i[5:4]` are ignored for shuffle and unshuffle.
- R7: A control value of zero makes every operation pass the (word-masked) data through unchanged.
- R8: Reverse, shuffle and unshuffle preserve the number of set bits. OR-combine never clears an input bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 reverse, 01 OR-combine, 10 shuffle, 11 unshuffle |
| word_i | input | 1 | 32-bit word mode |
| data_i | input | 64 | Data word to permute |
| ctrl_i | input | 6 | Stage enable bits |
| result_o | output | 64 | Registered permutation result |

## Verification
Two of this block's functions meet in the same cycle when word mode is asserted while a control bit that word mode must suppress is set. Examples are `ctrl_i[5]` for reverse and `ctrl_i[4]` for shuffle. In that case the masking and the stage enables act on the same operation. The bench provokes this with control values 63 and 31 in word mode. It judges the result against a model that first masks the data and the control to their word-mode widths and then applies the index-XOR or staged-mask definition. A wrong result in the upper half, or a leak of the full-width stage into the lower half, is reported as a mismatch against that model.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    typedef enum logic [1:0] {
        BP_REV   = 2'b00,
        BP_ORC   = 2'b01,
        BP_SHF   = 2'b10,
        BP_UNSHF = 2'b11
    } bp_op_e;

endpackage

// File: rtl/bperm_ctl.sv
// Applies word mode to the data and derives the per-stage enables.
module bperm_ctl #(
    parameter int W  = 64,
    parameter int LG = $clog2(W)
) (
    input  logic          word_i,
    input  logic [W-1:0]  data_i,
    input  logic [LG-1:0] ctrl_i,
    output logic [W-1:0]  data_o,
    output logic [LG-1:0] rev_en_o,
    output logic [LG-2:0] shf_en_o
);
    localparam int HW = W / 2;

    always_comb begin
        data_o   = data_i;
        rev_en_o = ctrl_i;
        shf_en_o = ctrl_i[LG-2:0];
        if (word_i) begin
            data_o[W-1:HW]     = '0;
            rev_en_o[LG-1]     = 1'b0;
            shf_en_o[LG-2]     = 1'b0;
        end
    end
endmodule

// File: rtl/bperm_swap_stage.sv
// One butterfly stage: swaps (or OR-merges) neighbouring groups of 2**K bits.
module bperm_swap_stage #(
    parameter int W = 64,
    parameter int K = 0
) (
    input  logic [W-1:0] x_i,
    input  logic         en_i,
    input  logic         orc_i,
    output logic [W-1:0] x_o
);
    localparam int N = 1 << K;

    function automatic logic [W-1:0] low_side();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            m[i] = ((i >> K) & 1) == 0;
        end
        return m;
    endfunction

    localparam logic [W-1:0] MLO = low_side();
    localparam logic [W-1:0] MHI = ~MLO;

    logic [W-1:0] swapped;

    always_comb begin
        swapped = ((x_i & MLO) << N) | ((x_i & MHI) >> N);
        if (!en_i) begin
            x_o = x_i;
        end else if (orc_i) begin
            x_o = x_i | swapped;
        end else begin
            x_o = swapped;
        end
    end
endmodule

// File: rtl/bperm_shuf_slot.sv
// One slot of the shuffle chain. In forward order the slot runs stage KF,
// in inverse order it runs stage KU. Stage k swaps the inner quarters of
// every group of 2**(k+2) bits.
module bperm_shuf_slot #(
    parameter int W  = 64,
    parameter int KF = 0,
    parameter int KU = 0
) (
    input  logic [W-1:0] x_i,
    input  logic         inv_i,
    input  logic         en_fwd_i,
    input  logic         en_inv_i,
    output logic [W-1:0] x_o
);
    function automatic logic [W-1:0] quarter(input int k, input bit upper);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            if (upper) m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
            else       m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
        end
        return m;
    endfunction

    localparam logic [W-1:0] LF = quarter(KF, 1'b1);
    localparam logic [W-1:0] RF = quarter(KF, 1'b0);
    localparam logic [W-1:0] LU = quarter(KU, 1'b1);
    localparam logic [W-1:0] RU = quarter(KU, 1'b0);
    localparam int NF = 1 << KF;
    localparam int NU = 1 << KU;

    logic [W-1:0] fwd_val;
    logic [W-1:0] inv_val;

    always_comb begin
        fwd_val = (x_i & ~(LF | RF)) | ((x_i << NF) & LF) | ((x_i >> NF) & RF);
        inv_val = (x_i & ~(LU | RU)) | ((x_i << NU) & LU) | ((x_i >> NU) & RU);
        if (inv_i) begin
            x_o = en_inv_i ? inv_val : x_i;
        end else begin
            x_o = en_fwd_i ? fwd_val : x_i;
        end
    end
endmodule

// File: rtl/bperm_net.sv
// Butterfly network: a swap chain for reverse / OR-combine and a shuffle
// chain whose slot order flips for unshuffle.
module bperm_net
    import bperm_pkg::*;
#(
    parameter int W  = 64,
    parameter int LG = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  bp_op_e        op_i,
    input  logic [LG-1:0] rev_en_i,
    input  logic [LG-2:0] shf_en_i,
    output logic [W-1:0]  res_o
);
    localparam int NS = LG - 1;

    logic [W-1:0] sw_c [0:LG];
    logic [W-1:0] sh_c [0:NS];
    logic         is_orc;
    logic         is_inv;

    assign is_orc  = (op_i == BP_ORC);
    assign is_inv  = (op_i == BP_UNSHF);
    assign sw_c[0] = data_i;
    assign sh_c[0] = data_i;

    for (genvar k = 0; k < LG; k++) begin : g_swap
        bperm_swap_stage #(.W(W), .K(k)) u_stage (
            .x_i   (sw_c[k]),
            .en_i  (rev_en_i[k]),
            .orc_i (is_orc),
            .x_o   (sw_c[k+1])
        );
    end

    for (genvar j = 0; j < NS; j++) begin : g_shuf
        bperm_shuf_slot #(.W(W), .KF(NS - 1 - j), .KU(j)) u_slot (
            .x_i      (sh_c[j]),
            .inv_i    (is_inv),
            .en_fwd_i (shf_en_i[NS-1-j]),
            .en_inv_i (shf_en_i[j]),
            .x_o      (sh_c[j+1])
        );
    end

    always_comb begin
        unique case (op_i)
            BP_REV, BP_ORC:   res_o = sw_c[LG];
            BP_SHF, BP_UNSHF: res_o = sh_c[NS];
            default:          res_o = sw_c[LG];
        endcase
    end
endmodule

// File: rtl/bperm_unit.sv
// Top: word-mode control, butterfly network, registered result.
module bperm_unit
    import bperm_pkg::*;
#(
    parameter int W  = 64,
    localparam int LG = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_i,
    input  logic          word_i,
    input  logic [W-1:0]  data_i,
    input  logic [LG-1:0] ctrl_i,
    output logic [W-1:0]  result_o
);
    logic [W-1:0]  data_eff;
    logic [LG-1:0] rev_en;
    logic [LG-2:0] shf_en;
    logic [W-1:0]  net_res;
    bp_op_e        op_sel;

    assign op_sel = bp_op_e'(op_i);

    bperm_ctl #(.W(W), .LG(LG)) u_ctl (
        .word_i   (word_i),
        .data_i   (data_i),
        .ctrl_i   (ctrl_i),
        .data_o   (data_eff),
        .rev_en_o (rev_en),
        .shf_en_o (shf_en)
    );

    bperm_net #(.W(W), .LG(LG)) u_net (
        .data_i   (data_eff),
        .op_i     (op_sel),
        .rev_en_i (rev_en),
        .shf_en_i (shf_en),
        .res_o    (net_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
        end else begin
            result_o <= net_res;
        end
    end
endmodule

// File: rtl/bperm_unit_chk.sv
module bperm_unit_chk #(
    parameter int W  = 64,
    parameter int LG = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op_i,
    input logic          word_i,
    input logic [W-1:0]  data_i,
    input logic [LG-1:0] ctrl_i,
    input logic [W-1:0]  result_o
);
    localparam int HW = W / 2;

    logic [W-1:0] din_eff;
    assign din_eff = word_i ? {{HW{1'b0}}, data_i[HW-1:0]} : data_i;

    // R1: reset clears the output register
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> result_o == '0);

    // R6: word mode leaves the upper half zero
    a_r6_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        word_i |=> result_o[W-1:HW] == '0);

    // R8: reverse keeps the set-bit count
    a_r8_rev_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 2'b00 |=> $countones(result_o) == $countones($past(din_eff)));

    // R8: shuffle and unshuffle keep the set-bit count
    a_r8_shuffle_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        op_i[1] |=> $countones(result_o) == $countones($past(din_eff)));

    // R3: OR-combine never clears an input bit
    a_r3_orc_covers_input: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 2'b01 |=> ($past(din_eff) & ~result_o) == '0);

    // R7: zero control passes the data through
    a_r7_zero_ctrl_identity: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i == '0 |=> result_o == $past(din_eff));
endmodule

bind bperm_unit bperm_unit_chk #(.W(W), .LG(LG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .word_i   (word_i),
    .data_i   (data_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o)
);

// File: tb/bperm_unit_test.sv
module bperm_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_s = 2'b00;
    logic        word_s = 1'b0;
    logic [63:0] data_s = '0;
    logic [5:0]  ctrl_s = '0;
    logic [63:0] result_o;
    logic        vld = 1'b0;
    logic        done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bperm_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_s),
        .word_i   (word_s),
        .data_i   (data_s),
        .ctrl_i   (ctrl_s),
        .result_o (result_o)
    );

    // ---------------- reference models ----------------
    function automatic logic [63:0] m_rev(input logic [63:0] x, input int c);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = x[i ^ c];
        return r;
    endfunction

    function automatic logic [63:0] m_orc(input logic [63:0] x, input int c);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                if ((((i ^ j) & ~c) & 63) == 0) r[i] = r[i] | x[j];
        return r;
    endfunction

    function automatic logic [63:0] m_stg(input logic [63:0] x, input logic [63:0] l,
                                          input logic [63:0] rm, input int n);
        return (x & ~(l | rm)) | ((x << n) & l) | ((x >> n) & rm);
    endfunction

    function automatic logic [63:0] m_one(input logic [63:0] x, input int k);
        case (k)
            4: return m_stg(x, 64'h0000ffff00000000, 64'h00000000ffff0000, 16);
            3: return m_stg(x, 64'h00ff000000ff0000, 64'h0000ff000000ff00, 8);
            2: return m_stg(x, 64'h0f000f000f000f00, 64'h00f000f000f000f0, 4);
            1: return m_stg(x, 64'h3030303030303030, 64'h0c0c0c0c0c0c0c0c, 2);
            default: return m_stg(x, 64'h4444444444444444, 64'h2222222222222222, 1);
        endcase
    endfunction

    function automatic logic [63:0] m_shf(input logic [63:0] x, input int c, input bit inv);
        logic [63:0] r = x;
        for (int s = 0; s < 5; s++) begin
            int k = inv ? s : 4 - s;
            if ((c >> k) & 1) r = m_one(r, k);
        end
        return r;
    endfunction

    function automatic logic [63:0] m_transpose(input logic [63:0] x);
        logic [63:0] r;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) r[8*b+a] = x[8*a+b];
        return r;
    endfunction

    function automatic logic [63:0] m_full(input logic [1:0] op, input bit w,
                                           input logic [63:0] d, input int c);
        logic [63:0] x = w ? {32'h0, d[31:0]} : d;
        int cr = w ? (c & 31) : (c & 63);
        int cs = w ? (c & 15) : (c & 31);
        case (op)
            2'b00:   return m_rev(x, cr);
            2'b01:   return m_orc(x, cr);
            2'b10:   return m_shf(x, cs, 1'b0);
            default: return m_shf(x, cs, 1'b1);
        endcase
    endfunction

    // ---------------- driver ----------------
    task automatic send(input logic [1:0] op, input bit w, input logic [63:0] d,
                        input logic [5:0] c, input logic [63:0] expv, input string tag);
        @(negedge clk);
        op_s = op; word_s = w; data_s = d; ctrl_s = c; vld = 1'b1;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
    endtask

    task automatic send_m(input logic [1:0] op, input bit w, input logic [63:0] d,
                          input logic [5:0] c, input string tag);
        send(op, w, d, c, m_full(op, w, d, int'(c)), tag);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            logic took;
            @(posedge clk);
            took = vld;
            #(CLK_PERIOD/4);
            if (took && exp_q.size() > 0) begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (result_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, result_o, e);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [63:0] x;
        logic [63:0] y;
        logic [63:0] bs;
        logic [63:0] br;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result_o !== 64'h0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %h expected %h", result_o, 64'h0);
        end
        rst_n = 1'b1;

        x = 64'h0123_4567_89ab_cdef;
        // R7: zero control is identity for every op
        for (int op = 0; op < 4; op++) send(2'(op), 1'b0, x, 6'd0, x, "R7 zero ctrl");
        send(2'b10, 1'b1, x, 6'd0, {32'h0, x[31:0]}, "R7 zero ctrl word");

        // R2: full reversal and byte swap
        for (int i = 0; i < 64; i++) br[i] = x[63-i];
        for (int b = 0; b < 8; b++) bs[8*b +: 8] = x[8*(7-b) +: 8];
        send(2'b00, 1'b0, x, 6'd63, br, "R2 bit reverse");
        send(2'b00, 1'b0, x, 6'd56, bs, "R2 byte swap");
        send_m(2'b00, 1'b0, 64'hF00D_0000_0000_0001, 6'd5, "R2 partial");

        // R3: OR-combine
        send(2'b01, 1'b0, 64'h0000_0000_0000_0001, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, "R3 smear all");
        send(2'b01, 1'b0, 64'h0000_0100_0000_0001, 6'd7, 64'h0000_FF00_0000_00FF, "R3 byte smear");
        send_m(2'b01, 1'b0, x, 6'd18, "R3 mixed");

        // R4: shuffle, bit 5 ignored, and 8x8 transpose
        send_m(2'b10, 1'b0, x, 6'd31, "R4 shuffle 31");
        send(2'b10, 1'b0, x, 6'h2A, m_shf(x, 10, 1'b0), "R4 ctrl bit5 ignored");
        y = m_shf(m_shf(x, 31, 1'b0), 31, 1'b0);
        send(2'b10, 1'b0, y, 6'd31, m_transpose(x), "R4 transpose");

        // R5: unshuffle inverts shuffle for all controls
        for (int c = 0; c < 32; c++)
            send(2'b11, 1'b0, m_shf(x ^ 64'(c), c, 1'b0), 6'(c), x ^ 64'(c), "R5 inverse");
        send(2'b11, 1'b0, x, 6'h3F, m_shf(x, 31, 1'b1), "R5 ctrl bit5 ignored");

        // R6: word mode with suppressed control bits set
        send(2'b00, 1'b1, x, 6'd63, m_rev({32'h0, x[31:0]}, 31), "R6 word reverse");
        send(2'b01, 1'b1, x, 6'd32, {32'h0, x[31:0]}, "R6 word orc bit5 ignored");
        send(2'b10, 1'b1, x, 6'd31, m_shf({32'h0, x[31:0]}, 15, 1'b0), "R6 word shuffle");
        send(2'b11, 1'b1, x, 6'd16, {32'h0, x[31:0]}, "R6 word unshuffle bit4 ignored");

        // R1/R8: back-to-back mixed traffic
        for (int i = 0; i < 60; i++) begin
            logic [63:0] d = {$urandom, $urandom};
            send_m(2'($urandom), 1'($urandom), d, 6'($urandom), "R8 random");
        end

        @(negedge clk);
        vld = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule